// File: doc/BRIEF.md
# RTC register and interrupt controller

This block is the register front end of a real-time clock. Software reaches it through two byte ports. A write to the even port selects a register. A read or write at the odd port then moves the selected byte. Behind the ports sit four status registers (A, B, C, D) and a parameterised byte array. The array holds the time, date and alarm bytes and general storage. The block stores bytes only. The timekeeping counters, the periodic divider and the alarm comparator are elsewhere.

External logic sends single-cycle event pulses:
- a periodic tick,
- an alarm match,
- an update-begin strobe,
- an update-complete strobe.

The block records each event as a flag in register C. It merges the flags that register B enables into one level-high interrupt request. That request stays high until software reads register C. While the SET bit of register B is high, the alarm and update events are frozen out. Register C is then only cleared by a read.

The request channel uses valid/ready. `req_ready` is always high, so the block never applies back-pressure and accepts one request per cycle. Every read, whether at the even or the odd port, produces one `rsp_valid` pulse with its byte in the following cycle. The response channel has no ready, so the requester must sink each response in the cycle it appears.

Top module: `rtc_regfile_ctrl`

## Requirements
- R1: A write to the even port (`req_addr`=0) stores bits 6:0 of the written byte as the register index. Bit 7 is discarded.
- R2: A read at the even port returns 0xFF. Every accepted read gives exactly one `rsp_valid` pulse one cycle later, with the byte on `rsp_data`. `req_ready` is always 1.
- R3: An odd-port write is ignored when the stored index is at or above NREGS (default 64). It does not alias onto a lower byte. An odd-port read at such an index returns 0xFF.
- R4: After reset, A, B and C read 0x00 and D reads 0x80. Writes to C (index 12) and D (index 13) are ignored.
- R5: A write to A (index 10) replaces bits 6:0 and keeps the update-in-progress bit (bit 7). An update-begin pulse sets bit 7 of A while SET is clear.
- R6: A read of C (index 12) returns the value C held before the read and clears C to 0x00. If the interrupt was high, it drops in the next cycle.
- R7: The interrupt bit of C (bit 7) and `irq` go high when any flag in C (PF bit 6, AF bit 5, UF bit 4) has its enable set in B (PIE bit 6, AIE bit 5, UIE bit 4). They stay high until C is read, even if the enable is later cleared.
- R8: An alarm pulse sets AF only when SET (bit 7 of B) is clear. A periodic pulse sets PF whatever the state of SET.
- R9: An update-complete pulse is ignored while SET is high. Otherwise it sets UF and clears bit 7 of A.
- R10: A write to B (index 11) with bit 7 high clears bit 7 of A.
- R11: A write to B that turns UIE from 0 to 1 while UF is pending raises `irq` in the next cycle.
- R12: Storage bytes (every index below NREGS other than 10 to 13) read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| ev_periodic | input | 1 | Periodic tick pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_upd_begin | input | 1 | Update-begin pulse |
| ev_upd_done | input | 1 | Update-complete pulse |
| irq | output | 1 | Level-high interrupt request |

## Verification
Several properties are checked only when their own event inputs are quiet in the same cycle:
- the clear-on-read property assumes no event pulse lands in the cycle that reads C;
- the keep-UIP property assumes no update pulse coincides with the write to A;
- the unmasking property assumes C is not read in the cycle that enables UIE.

The stimulus keeps to these conditions. It never drives an event pulse in the same cycle as a bus request, and it issues one request at a time, each followed by an idle cycle. The bench therefore never relies on the same-cycle priority between an event and a read or write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int IDX_W = 7;

  localparam int C_IRQF = 7;
  localparam int C_PF   = 6;
  localparam int C_AF   = 5;
  localparam int C_UF   = 4;

  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;

  localparam int A_UIP  = 7;

  typedef struct packed {
    logic periodic;
    logic alarm;
    logic upd_begin;
    logic upd_done;
  } rtc_events_t;
endpackage

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
  import rtc_pkg::*;
#(
  parameter int NREGS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_addr,
  input  logic [7:0]       req_wdata,
  output logic [IDX_W-1:0] idx,
  output logic             idx_ok,
  output logic             data_wr,
  output logic             data_rd,
  output logic             index_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (req_valid && req_write && !req_addr)
      idx <= req_wdata[IDX_W-1:0];
  end

  assign idx_ok   = (32'(idx) < NREGS);
  assign data_wr  = req_valid && req_write && req_addr && idx_ok;
  assign data_rd  = req_valid && !req_write && req_addr;
  assign index_rd = req_valid && !req_write && !req_addr;

  a_r1_index_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_addr) |=> (idx == $past(req_wdata[IDX_W-1:0])));
endmodule

// File: rtl/rtc_storage.sv
module rtc_storage #(
  parameter int NREGS = 64,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= 8'h00;
      else if (we && (32'(addr) == g))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_pkg::*;
#(
  parameter logic [7:0] D_VALUE = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_a,
  input  logic        wr_b,
  input  logic        rd_c,
  input  logic [7:0]  wdata,
  input  rtc_events_t ev,
  output logic [7:0]  reg_a,
  output logic [7:0]  reg_b,
  output logic [7:0]  reg_c,
  output logic [7:0]  reg_d,
  output logic        irq_o
);
  logic       set_mode;
  logic       uip_n;
  logic [7:0] a_n, b_n, c_n;
  logic [2:0] new_flags, flags_n;
  logic       hit, irqf_n;

  assign set_mode = reg_b[B_SET];

  always_comb begin
    if (wr_b && wdata[B_SET])
      uip_n = 1'b0;
    else if (ev.upd_done && !set_mode)
      uip_n = 1'b0;
    else if (ev.upd_begin && !set_mode)
      uip_n = 1'b1;
    else
      uip_n = reg_a[A_UIP];
    a_n = {uip_n, (wr_a ? wdata[6:0] : reg_a[6:0])};
    b_n = wr_b ? wdata : reg_b;
    new_flags = {ev.periodic, ev.alarm && !set_mode, ev.upd_done && !set_mode};
    flags_n = (rd_c ? 3'b000 : reg_c[C_PF:C_UF]) | new_flags;
    hit = |(flags_n & b_n[B_PIE:B_UIE]);
    irqf_n = (rd_c ? 1'b0 : reg_c[C_IRQF]) | hit;
    c_n = {irqf_n, flags_n, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= 8'h00;
      reg_b <= 8'h00;
      reg_c <= 8'h00;
    end else begin
      reg_a <= a_n;
      reg_b <= b_n;
      reg_c <= c_n;
    end
  end

  assign reg_d = D_VALUE;
  assign irq_o = reg_c[C_IRQF];

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !ev.periodic && !ev.alarm && !ev.upd_done) |=> (reg_c == 8'h00 && !irq_o));

  a_r5_uip_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && !ev.upd_done && !ev.upd_begin) |=> (reg_a[A_UIP] == $past(reg_a[A_UIP])));

  a_r8_set_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !rd_c) |=> (reg_c[C_AF] == $past(reg_c[C_AF]) && reg_c[C_UF] == $past(reg_c[C_UF])));

  a_r10_set_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[B_SET]) |=> !reg_a[A_UIP]);

  a_r11_uie_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata[B_UIE] && !reg_b[B_UIE] && reg_c[C_UF] && !rd_c) |=> irq_o);

  a_r7_enabled_flag_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(reg_c[C_PF:C_UF] & reg_b[B_PIE:B_UIE])) |-> irq_o);
endmodule

// File: rtl/rtc_regfile_ctrl.sv
module rtc_regfile_ctrl
  import rtc_pkg::*;
#(
  parameter int NREGS = 64,
  parameter int IDX_A = 10,
  parameter int IDX_B = 11,
  parameter int IDX_C = 12,
  parameter int IDX_D = 13,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  input  logic       ev_periodic,
  input  logic       ev_alarm,
  input  logic       ev_upd_begin,
  input  logic       ev_upd_done,
  output logic       irq
);
  logic [IDX_W-1:0] idx;
  logic             idx_ok, data_wr, data_rd, index_rd;
  logic             sel_a, sel_b, sel_c, sel_d, sel_stat;
  logic [7:0]       reg_a, reg_b, reg_c, reg_d, mem_rdata, rd_mux;
  rtc_events_t      ev;

  assign req_ready = 1'b1;
  assign ev = '{periodic: ev_periodic, alarm: ev_alarm,
                upd_begin: ev_upd_begin, upd_done: ev_upd_done};

  rtc_port_decode #(.NREGS(NREGS)) u_dec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .idx(idx), .idx_ok(idx_ok),
    .data_wr(data_wr), .data_rd(data_rd), .index_rd(index_rd)
  );

  assign sel_a    = (32'(idx) == IDX_A);
  assign sel_b    = (32'(idx) == IDX_B);
  assign sel_c    = (32'(idx) == IDX_C);
  assign sel_d    = (32'(idx) == IDX_D);
  assign sel_stat = sel_a || sel_b || sel_c || sel_d;

  rtc_storage #(.NREGS(NREGS)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(data_wr && !sel_stat),
    .addr(idx[AW-1:0]), .wdata(req_wdata), .rdata(mem_rdata)
  );

  rtc_status_regs u_stat (
    .clk(clk), .rst_n(rst_n),
    .wr_a(data_wr && sel_a), .wr_b(data_wr && sel_b),
    .rd_c(data_rd && idx_ok && sel_c), .wdata(req_wdata), .ev(ev),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .irq_o(irq)
  );

  always_comb begin
    if (!idx_ok)    rd_mux = 8'hFF;
    else if (sel_a) rd_mux = reg_a;
    else if (sel_b) rd_mux = reg_b;
    else if (sel_c) rd_mux = reg_c;
    else if (sel_d) rd_mux = reg_d;
    else            rd_mux = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= data_rd || index_rd;
      if (data_rd || index_rd)
        rsp_data <= index_rd ? 8'hFF : rd_mux;
    end
  end

  a_r2_even_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    index_rd |=> (rsp_valid && rsp_data == 8'hFF));

  a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r4_d_constant: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && sel_d) |=> (rsp_data == 8'h80));
endmodule

// File: tb/sim_rtc_regfile_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_regfile_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic req_ready, rsp_valid, irq;
  logic [7:0] rsp_data;
  logic ev_periodic = 1'b0, ev_alarm = 1'b0, ev_upd_begin = 1'b0, ev_upd_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  rtc_regfile_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ev_periodic(ev_periodic),
    .ev_alarm(ev_alarm), .ev_upd_begin(ev_upd_begin), .ev_upd_done(ev_upd_done),
    .irq(irq)
  );

  // Monitor: pops the scoreboard on each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected response actual=%02h expected=none", rsp_data);
      end else begin
        logic [7:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rsp_data !== e) begin
          n_bad++;
          $display("FAIL %s actual=%02h expected=%02h", t, rsp_data, e);
        end
      end
    end
  end

  task automatic bus(input bit wr, input bit ad, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = 1'b0; req_wdata = 8'h00;
  endtask

  task automatic wr(input logic [7:0] ix, input logic [7:0] d);
    bus(1'b1, 1'b0, ix);
    bus(1'b1, 1'b1, d);
  endtask

  task automatic rd(input logic [7:0] ix, input logic [7:0] e, input string t);
    bus(1'b1, 1'b0, ix);
    q_exp.push_back(e);
    q_tag.push_back(t);
    bus(1'b0, 1'b1, 8'h00);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_periodic = 1'b1;
      1: ev_alarm = 1'b1;
      2: ev_upd_begin = 1'b1;
      default: ev_upd_done = 1'b1;
    endcase
    @(negedge clk);
    ev_periodic = 1'b0; ev_alarm = 1'b0; ev_upd_begin = 1'b0; ev_upd_done = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_chk++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    chk_irq(1'b0, "R4 reset irq");
    n_chk++;
    if (req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R2 req_ready actual=%0b expected=1", req_ready);
    end
    rd(10, 8'h00, "R4 reset A");
    rd(11, 8'h00, "R4 reset B");
    rd(12, 8'h00, "R4 reset C");
    rd(13, 8'h80, "R4 reset D");

    // R1: bit 7 of the index byte is dropped
    wr(8'h85, 8'h3C);
    rd(5, 8'h3C, "R1 index low 7 bits");
    // R12: general storage
    wr(20, 8'hA5);
    rd(20, 8'hA5, "R12 storage byte 20");
    wr(63, 8'h5A);
    rd(63, 8'h5A, "R12 storage byte 63");
    // R2: even read
    q_exp.push_back(8'hFF); q_tag.push_back("R2 even port read");
    bus(1'b0, 1'b0, 8'h00);
    // R3: out of range write does not alias
    wr(6, 8'h00);
    wr(70, 8'h11);
    rd(6, 8'h00, "R3 no alias to byte 6");
    rd(70, 8'hFF, "R3 out of range read");
    // R4: C and D read-only
    wr(12, 8'hFF);
    chk_irq(1'b0, "R4 write C no irq");
    rd(12, 8'h00, "R4 write C ignored");
    wr(13, 8'h00);
    rd(13, 8'h80, "R4 write D ignored");
    // R5: UIP preserved on write to A
    pulse(2);
    rd(10, 8'h80, "R5 update begin sets UIP");
    wr(10, 8'h25);
    rd(10, 8'hA5, "R5 UIP kept on write");
    // R9: update complete clears UIP, sets UF
    pulse(3);
    chk_irq(1'b0, "R9 UF without UIE");
    rd(10, 8'h25, "R9 UIP cleared");
    rd(12, 8'h10, "R9 UF set");
    // R7/R6: periodic with PIE
    wr(11, 8'h40);
    pulse(0);
    chk_irq(1'b1, "R7 periodic irq");
    rd(12, 8'hC0, "R6 C value on read");
    chk_irq(1'b0, "R6 irq dropped by read");
    rd(12, 8'h00, "R6 C cleared");
    // R8: alarm with AIE
    wr(11, 8'h20);
    pulse(1);
    chk_irq(1'b1, "R8 alarm irq");
    rd(12, 8'hA0, "R8 AF and IRQF");
    // R10: SET clears UIP
    wr(11, 8'h00);
    pulse(2);
    rd(10, 8'hA5, "R10 UIP set before");
    wr(11, 8'hA0);
    rd(10, 8'h25, "R10 SET clears UIP");
    // R8/R9: frozen under SET
    pulse(1);
    chk_irq(1'b0, "R8 alarm frozen under SET");
    pulse(3);
    rd(12, 8'h00, "R9 update ignored under SET");
    pulse(0);
    rd(12, 8'h40, "R8 periodic under SET");
    // R11: enabling UIE with UF pending
    wr(11, 8'h00);
    pulse(3);
    chk_irq(1'b0, "R11 UF pending masked");
    wr(11, 8'h10);
    chk_irq(1'b1, "R11 unmask raises irq");
    rd(12, 8'h90, "R11 C after unmask");
    pulse(3);
    chk_irq(1'b1, "R9 update with UIE");
    rd(12, 8'h90, "R9 C with UIE");
    // R7: sticky after enable cleared
    wr(11, 8'h40);
    pulse(0);
    wr(11, 8'h00);
    chk_irq(1'b1, "R7 sticky after disable");
    rd(12, 8'hC0, "R7 C sticky");
    chk_irq(1'b0, "R6 irq after final read");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 missing responses actual=%0d expected=0", q_exp.size());
    end
    finish_run();
  end
endmodule